// File: doc/BRIEF.md
# Pixel Color Component Extractor

This block sits between a framebuffer fetch engine and a display output. Each cycle it takes one raw pixel word and cuts a red, a green and a blue field out of it. Software sets where each field sits and how wide it is, and it can read those settings back. Each channel's field is widened or narrowed to an 8-bit value. The result is registered, one cycle behind its input, together with a data-enable flag.

Each channel also holds a programmable default colour. That colour replaces the extracted value in several cases: the channel's field length is zero, the timing generator reports blanking, the fetch engine reports an underrun, or no pixel word is valid. Setting one channel's default to full scale makes underruns visible on screen as that colour. A pixel-size setting gives how many bytes make up a pixel. Bytes above that count are treated as zero.

Top module: `pix_chan_extract`

## Requirements
- R1: After reset, out_r, out_g, out_b and out_de are 0, and every configuration register reads back as 0.
- R2: Register addresses are: 0 pixel size, 1 red select, 2 green select, 3 blue select. A select register keeps bits [4:0] (offset), [11:8] (length) and [23:16] (default colour). The pixel-size register keeps bits [4:3] (bytes per pixel minus one). All other bits read back as 0.
- R3: Pixel bytes at or above the programmed bytes-per-pixel count read as zero during extraction. A size value of 0 means one byte.
- R4: A channel's field starts at pixel bit `offset`. Field bits that lie above the top of the pixel word read as zero.
- R5: A field of length 1 to 7 is placed in the top bits of the 8-bit output. Its bits are then repeated downward, most significant bit first, until all 8 bits are filled.
- R6: A field of length 8 is output unchanged. A field of length 9 to 15 outputs its 8 most significant bits.
- R7: A channel whose length is 0 outputs its default colour.
- R8: While in_visible is low, all three channels output their default colours and out_de is low.
- R9: While in_visible is high but in_underrun is high or pix_valid is low, all three channels output their default colours.
- R10: Colour outputs and out_de update exactly one clock after the pixel inputs they come from. out_de equals in_visible from that earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| pix_data | input | PIX_BYTES*8 | Raw pixel word |
| pix_valid | input | 1 | pix_data holds a fetched pixel |
| in_visible | input | 1 | Timing generator is in the active area |
| in_underrun | input | 1 | Fetch engine failed to deliver data in time |
| out_de | output | 1 | Registered data enable |
| out_r | output | 8 | Registered red component |
| out_g | output | 8 | Registered green component |
| out_b | output | 8 | Registered blue component |

## Verification
The bench sweeps every offset, every length and every bytes-per-pixel setting against pseudo-random pixel words. This targets several wrong designs. One ignores the pixel size and leaks upper bytes into fields. One lets an offset near the word top pull in garbage. One pads short fields with zeros instead of repeating them. One keeps the low bits of a long field rather than its top bits. Each sweep step also drives one blanking, underrun or invalid pixel, which catches a default colour that wins in the wrong case or loses in the right one. Read-back with all-ones writes catches reserved bits that are stored. Checking every pixel one cycle after it was driven catches any shift between the colours and the data enable.

// File: rtl/pix_chan_extract.sv
module pix_chan_extract #(
  parameter int PIX_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [PIX_BYTES*8-1:0] pix_data,
  input  logic                   pix_valid,
  input  logic                   in_visible,
  input  logic                   in_underrun,
  output logic                   out_de,
  output logic [7:0]             out_r,
  output logic [7:0]             out_g,
  output logic [7:0]             out_b
);
  localparam int PIX_W = PIX_BYTES * 8;
  localparam int BPP_W = (PIX_BYTES > 1) ? $clog2(PIX_BYTES) : 1;
  localparam int NCH   = 3;

  logic [BPP_W-1:0] fmt_q;
  logic [4:0]       off_q [NCH];
  logic [3:0]       len_q [NCH];
  logic [7:0]       def_q [NCH];
  logic [7:0]       col_q [NCH];
  logic             past_ok;
  logic [PIX_W-1:0] byte_mask;
  logic [PIX_W-1:0] pix_m;
  logic             use_def;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        off_q[c] <= '0;
        len_q[c] <= '0;
        def_q[c] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr == 2'd0) fmt_q <= cfg_wdata[3 +: BPP_W];
      else begin
        off_q[cfg_addr - 2'd1] <= cfg_wdata[4:0];
        len_q[cfg_addr - 2'd1] <= cfg_wdata[11:8];
        def_q[cfg_addr - 2'd1] <= cfg_wdata[23:16];
      end
    end
  end

  always_comb begin
    if (cfg_addr == 2'd0) cfg_rdata = 32'(fmt_q) << 3;
    else cfg_rdata = {8'h00, def_q[cfg_addr - 2'd1], 4'h0, len_q[cfg_addr - 2'd1],
                      3'h0, off_q[cfg_addr - 2'd1]};
    AST_RSVD_ZERO: assert (cfg_rdata[31:24] == 8'h00 && cfg_rdata[15:12] == 4'h0 &&
                           cfg_rdata[7:5] == 3'h0); // R2
  end

  for (genvar b = 0; b < PIX_BYTES; b++) begin : g_mask
    assign byte_mask[b*8 +: 8] = (BPP_W'(b) <= fmt_q) ? 8'hFF : 8'h00;
  end
  assign pix_m   = pix_data & byte_mask;
  assign use_def = !in_visible || in_underrun || !pix_valid;

  function automatic logic [7:0] expand(input logic [PIX_W-1:0] p,
                                        input logic [4:0] off, input logic [3:0] len);
    logic [PIX_W+14:0] sh;
    logic [14:0]       fld;
    logic [7:0]        o;
    int                l;
    sh  = {15'h0, p} >> off;
    fld = sh[14:0] & ((15'h1 << len) - 15'h1);
    l   = int'(len);
    o   = '0;
    for (int i = 0; i < 8; i++) begin
      if (l >= 8)     o[i] = fld[l - 8 + i];
      else if (l > 0) o[i] = fld[l - 1 - ((7 - i) % l)];
    end
    return o;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                          col_q[c] <= '0;
      else if (use_def || len_q[c] == '0)  col_q[c] <= def_q[c];
      else                                 col_q[c] <= expand(pix_m, off_q[c], len_q[c]);
    end

    AST_LEN0_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(len_q[c]) == 4'd0 |-> col_q[c] == $past(def_q[c])); // R7
    AST_BLANK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(in_visible) |-> col_q[c] == $past(def_q[c])); // R8
    AST_UNDERRUN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && ($past(in_underrun) || !$past(pix_valid)) |-> col_q[c] == $past(def_q[c])); // R9
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_de  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      out_de  <= in_visible;
      past_ok <= 1'b1;
    end
  end

  assign out_r = col_q[0];
  assign out_g = col_q[1];
  assign out_b = col_q[2];

  AST_DE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> out_de == $past(in_visible)); // R10
endmodule

// File: tb/test_pix_chan_extract.sv
module test_pix_chan_extract;
  localparam int PB = 4;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [PB*8-1:0] pix_data = '0;
  logic pix_valid = 1'b0, in_visible = 1'b0, in_underrun = 1'b0;
  logic out_de;
  logic [7:0] out_r, out_g, out_b;
  int checks = 0, fails = 0;
  int sz = 1;
  int offs[3], lens[3], defs[3];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  pix_chan_extract #(.PIX_BYTES(PB)) i_pix_chan_extract (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pix_data(pix_data),
    .pix_valid(pix_valid), .in_visible(in_visible), .in_underrun(in_underrun),
    .out_de(out_de), .out_r(out_r), .out_g(out_g), .out_b(out_b));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [31:0] p, input int o, input int l,
                                       input int d, input bit dflt);
    logic [63:0] m, f, acc;
    int bits;
    if (dflt || l == 0) return 8'(d);
    m = '0;
    for (int b = 0; b < sz; b++) m[b*8 +: 8] = p[b*8 +: 8];
    f = (m >> o) & ((64'd1 << l) - 64'd1);
    if (l >= 8) return 8'(f >> (l - 8));
    acc = '0; bits = 0;
    while (bits < 8) begin acc = (acc << l) | f; bits += l; end
    return 8'(acc >> (bits - 8));
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setch(input int c, input int o, input int l, input int d);
    offs[c] = o; lens[c] = l; defs[c] = d;
    wr(2'(c + 1), {8'h00, 8'(d), 4'h0, 4'(l), 3'h0, 5'(o)});
  endtask

  task automatic px(input string req, input bit v, input bit vi, input bit u);
    logic [31:0] p;
    bit dflt;
    seed = seed * 32'd1103515245 + 32'd12345;
    p = seed ^ {seed[15:0], seed[31:16]};
    pix_data = p; pix_valid = v; in_visible = vi; in_underrun = u;
    dflt = !vi || u || !v;
    @(negedge clk);
    chk({req, " red"},   {24'h0, out_r}, {24'h0, model(p, offs[0], lens[0], defs[0], dflt)});
    chk({req, " green"}, {24'h0, out_g}, {24'h0, model(p, offs[1], lens[1], defs[1], dflt)});
    chk({req, " blue"},  {24'h0, out_b}, {24'h0, model(p, offs[2], lens[2], defs[2], dflt)});
    chk({req, " de R10"}, {31'h0, out_de}, {31'h0, vi});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++) begin offs[c] = 0; lens[c] = 0; defs[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 r", {24'h0, out_r}, 0); chk("R1 g", {24'h0, out_g}, 0);
    chk("R1 b", {24'h0, out_b}, 0); chk("R1 de", {31'h0, out_de}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      cfg_addr = 2'(a); #1;
      chk("R1 rdata", cfg_rdata, 0);
    end
    // R2 read-back masks
    for (int a = 0; a < 4; a++) begin
      wr(2'(a), 32'hFFFF_FFFF);
      cfg_addr = 2'(a); #1;
      chk("R2 mask", cfg_rdata, (a == 0) ? 32'h0000_0018 : 32'h00FF_0F1F);
    end
    wr(2'd2, 32'h00A5_0713); cfg_addr = 2'd2; #1;
    chk("R2 green", cfg_rdata, 32'h00A5_0713);
    // R3..R9 sweep over size, length and offset
    for (int s = 1; s <= PB; s++) begin
      sz = s;
      wr(2'd0, 32'(s - 1) << 3);
      for (int l = 0; l < 16; l++) begin
        for (int o = 0; o < 32; o++) begin
          setch(0, o, l, (o * 7 + l) & 255);
          setch(1, 31 - o, 15 - l, 255);
          setch(2, o ^ 5, (l + 3) % 16, (l * 17) & 255);
          px("R3 R4 R5 R6 R7", 1'b1, 1'b1, 1'b0);
          case (o % 3)
            0: px("R8 blank", 1'b1, 1'b0, 1'b0);
            1: px("R9 underrun", 1'b1, 1'b1, 1'b1);
            default: px("R9 invalid", 1'b0, 1'b1, 1'b0);
          endcase
        end
      end
    end
    // R5 short field replication, explicit
    sz = 4; wr(2'd0, 32'h18);
    setch(0, 0, 3, 0); setch(1, 0, 1, 0); setch(2, 0, 8, 0);
    pix_data = 32'h0000_0005; pix_valid = 1'b1; in_visible = 1'b1; in_underrun = 1'b0;
    @(negedge clk);
    chk("R5 len3", {24'h0, out_r}, 32'hB6);
    chk("R5 len1", {24'h0, out_g}, 32'hFF);
    chk("R6 len8", {24'h0, out_b}, 32'h05);
    in_visible = 1'b0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule